// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block chooses which of a set of interrupt lines, eight by default, should be presented to the processor. Requests that are pending and not masked are ranked by their distance from a movable rotation base. The line at the base is the most urgent, and urgency falls as the line number steps upward and wraps around. The most urgent candidate is presented only if it outranks the most urgent line already in service. This lets nested handlers be interrupted only by more urgent sources.

Two mode flags change which in-service bits count toward the current level. With the masking override on, in-service lines that are currently masked stop blocking other lines. With cascade nesting on, and the instance acting as the primary controller, the in-service bit of the cascade input is ignored. A secondary controller can then raise a more urgent request through the same input.

Request capture, register programming and vector generation sit outside the block. The rotation base is an input that another block updates.

Top module: `rot_prio_resolver`

## Requirements
- R1: The candidate set is the request vector ANDed with the inverted mask vector. A masked request is never presented, and an unmasked request may be.
- R2: Line L has rank (L - base) mod NUM_LINES, and rank 0 is the most urgent. With nothing in service, the presented line is the candidate of lowest rank, so a candidate at the base line always wins.
- R3: When the candidate set is empty, pick_valid is 0.
- R4: A candidate is presented only when its rank is strictly lower than the rank of the most urgent counted in-service line. Equal or higher rank gives pick_valid 0.
- R5: With special_mask_en at 1, in-service bits whose mask bit is 1 do not count toward the current level.
- R6: With special_mask_en at 0, masked in-service bits still count and block candidates of equal or lower urgency.
- R7: When nested_en and is_master are both 1, in-service bit 2 (the cascade line) is ignored. If either flag is 0, that bit counts like any other.
- R8: int_level is a register. It equals the value pick_valid had at the previous rising clock edge, and it is 0 while rst_n is low.
- R9: pick_line is (winning rank + base) mod NUM_LINES when pick_valid is 1, and 0 when pick_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vec | input | NUM_LINES | Pending request bits |
| mask_vec | input | NUM_LINES | Mask bits, 1 = masked |
| isr_vec | input | NUM_LINES | In-service bits |
| rot_base | input | log2(NUM_LINES) | Line number holding rank 0 |
| special_mask_en | input | 1 | Masked in-service lines stop blocking |
| nested_en | input | 1 | Cascade nesting mode |
| is_master | input | 1 | Instance is the primary controller |
| pick_valid | output | 1 | A candidate outranks the current level (combinational) |
| pick_line | output | log2(NUM_LINES) | Winning line number (combinational) |
| int_level | output | 1 | Registered interrupt output |

## Verification
The bench targets the equal-rank case, where an off-by-one in the compare would present a line that is already in service. It also covers wrap-around of the rank when the base is nonzero; a design that ranks by raw line number would pick the wrong line there. The masking override and the cascade exception are each run with their enabling flags both set and cleared. A design that applied either one unconditionally would either block or release the wrong request. A full sweep over every base compares the picked line against a model that ranks by modular distance.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
  localparam int unsigned MAX_LINES = 32;

  // lowest set index of v within n bits; n when none set
  function automatic int unsigned first_set(logic [MAX_LINES-1:0] v, int unsigned n);
    int unsigned r;
    r = n;
    for (int i = MAX_LINES - 1; i >= 0; i--) begin
      if (i < int'(n) && v[i]) r = i;
    end
    return r;
  endfunction

  // modular addition for a power-of-two ring of n entries
  function automatic int unsigned ring_add(int unsigned a, int unsigned b, int unsigned n);
    return (a + b) & (n - 1);
  endfunction
endpackage

// File: rtl/rpr_rank.sv
module rpr_rank #(
  parameter int unsigned N = 8,
  localparam int unsigned IDX_W = $clog2(N),
  localparam int unsigned POS_W = IDX_W + 1
) (
  input  logic [N-1:0]     vec,
  input  logic [IDX_W-1:0] base,
  output logic [POS_W-1:0] pos
);
  logic [N-1:0] rotated;
  logic [rpr_pkg::MAX_LINES-1:0] wide;

  for (genvar g = 0; g < N; g++) begin : g_rot
    logic [IDX_W-1:0] src;
    assign src = IDX_W'(rpr_pkg::ring_add(g, base, N));
    assign rotated[g] = vec[src];
  end

  assign wide = rpr_pkg::MAX_LINES'(rotated);
  assign pos  = POS_W'(rpr_pkg::first_set(wide, N));
endmodule

// File: rtl/rpr_level_filter.sv
module rpr_level_filter #(
  parameter int unsigned N = 8,
  parameter int unsigned CASCADE_LINE = 2
) (
  input  logic [N-1:0] isr_vec,
  input  logic [N-1:0] mask_vec,
  input  logic         special_mask_en,
  input  logic         nested_en,
  input  logic         is_master,
  output logic [N-1:0] counted
);
  logic [N-1:0] cascade_clr;
  always_comb begin
    cascade_clr = '0;
    cascade_clr[CASCADE_LINE] = nested_en & is_master;
  end
  assign counted = isr_vec & ~(special_mask_en ? mask_vec : '0) & ~cascade_clr;
endmodule

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver #(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned CASCADE_LINE = 2,
  localparam int unsigned IDX_W = $clog2(NUM_LINES),
  localparam int unsigned POS_W = IDX_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] req_vec,
  input  logic [NUM_LINES-1:0] mask_vec,
  input  logic [NUM_LINES-1:0] isr_vec,
  input  logic [IDX_W-1:0]     rot_base,
  input  logic                 special_mask_en,
  input  logic                 nested_en,
  input  logic                 is_master,
  output logic                 pick_valid,
  output logic [IDX_W-1:0]     pick_line,
  output logic                 int_level
);
  logic [NUM_LINES-1:0] cand_vec;
  logic [NUM_LINES-1:0] counted_isr;
  logic [POS_W-1:0]     req_pos;
  logic [POS_W-1:0]     cur_pos;

  assign cand_vec = req_vec & ~mask_vec;

  rpr_level_filter #(.N(NUM_LINES), .CASCADE_LINE(CASCADE_LINE)) u_filter (
    .isr_vec(isr_vec), .mask_vec(mask_vec), .special_mask_en(special_mask_en),
    .nested_en(nested_en), .is_master(is_master), .counted(counted_isr)
  );

  rpr_rank #(.N(NUM_LINES)) u_rank_req (.vec(cand_vec),    .base(rot_base), .pos(req_pos));
  rpr_rank #(.N(NUM_LINES)) u_rank_cur (.vec(counted_isr), .base(rot_base), .pos(cur_pos));

  assign pick_valid = req_pos < cur_pos;
  assign pick_line  = pick_valid
                    ? IDX_W'(rpr_pkg::ring_add(int'(req_pos[IDX_W-1:0]), rot_base, NUM_LINES))
                    : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) int_level <= 1'b0;
    else        int_level <= pick_valid;
  end
endmodule

// File: rtl/rpr_checks.sv
module rpr_checks #(
  parameter int unsigned N = 8,
  parameter int unsigned CASCADE_LINE = 2,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N-1:0]     req_vec,
  input logic [N-1:0]     mask_vec,
  input logic [N-1:0]     isr_vec,
  input logic [IDX_W-1:0] rot_base,
  input logic             nested_en,
  input logic             is_master,
  input logic             pick_valid,
  input logic [IDX_W-1:0] pick_line,
  input logic             int_level
);
  p_masked_never_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> (req_vec[pick_line] && !mask_vec[pick_line]));

  p_base_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vec[rot_base] && !mask_vec[rot_base] && isr_vec == '0) |-> (pick_valid && pick_line == rot_base));

  p_empty_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_vec & ~mask_vec) == '0) |-> !pick_valid);

  p_not_in_service_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_valid && !(nested_en && is_master && pick_line == IDX_W'(CASCADE_LINE))) |-> !isr_vec[pick_line]);

  p_int_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |=> int_level);

  p_int_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pick_valid |=> !int_level);

  p_idle_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pick_valid |-> pick_line == '0);
endmodule

bind rot_prio_resolver rpr_checks #(.N(NUM_LINES), .CASCADE_LINE(CASCADE_LINE)) u_checks (
  .clk(clk), .rst_n(rst_n), .req_vec(req_vec), .mask_vec(mask_vec), .isr_vec(isr_vec),
  .rot_base(rot_base), .nested_en(nested_en), .is_master(is_master),
  .pick_valid(pick_valid), .pick_line(pick_line), .int_level(int_level)
);

// File: tb/tb_rot_prio_resolver.sv
module tb_rot_prio_resolver;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0, msk = '0, isr = '0;
  logic [2:0] base = '0;
  logic       sm = 1'b0, nest = 1'b0, mas = 1'b0;
  logic       pick_valid, int_level;
  logic [2:0] pick_line;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  rot_prio_resolver dut (
    .clk(clk), .rst_n(rst_n), .req_vec(req), .mask_vec(msk), .isr_vec(isr),
    .rot_base(base), .special_mask_en(sm), .nested_en(nest), .is_master(mas),
    .pick_valid(pick_valid), .pick_line(pick_line), .int_level(int_level)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // model: rank each line by modular distance from base, keep the smallest
  task automatic model(output bit v, output int line);
    int best_req = 99, best_cur = 99;
    line = 0;
    for (int l = 0; l < 8; l++) begin
      int d = (l - int'(base) + 8) % 8;
      bit counts = isr[l] && !(sm && msk[l]) && !(nest && mas && l == 2);
      if (req[l] && !msk[l] && d < best_req) begin best_req = d; line = l; end
      if (counts && d < best_cur) best_cur = d;
    end
    v = best_req < best_cur;
    if (!v) line = 0;
  endtask

  task automatic apply(input string tag, input logic [7:0] r, input logic [7:0] m,
                       input logic [7:0] s, input logic [2:0] b,
                       input bit e_v, input int e_line);
    bit mv; int ml;
    @(negedge clk);
    req = r; msk = m; isr = s; base = b;
    #1;
    model(mv, ml);
    check({tag, " model-valid"}, int'(mv), int'(e_v));
    check({tag, " valid"}, int'(pick_valid), int'(e_v));
    check({tag, " line"}, int'(pick_line), e_line);
    @(negedge clk);
    check({tag, " R8 int_level"}, int'(int_level), int'(e_v));
  endtask

  task automatic t_reset;
    req = 8'hFF; #1;
    check("R8 reset int_level", int'(int_level), 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_r1;
    sm = 0; nest = 0; mas = 0;
    apply("R1 mask lowest", 8'h0F, 8'h01, 8'h00, 3'd0, 1, 1);
    apply("R1 mask all but 6", 8'hFF, 8'hBF, 8'h00, 3'd0, 1, 6);
  endtask

  task automatic t_r2;
    apply("R2 base7", 8'h81, 8'h00, 8'h00, 3'd7, 1, 7);
    apply("R2 base0", 8'h81, 8'h00, 8'h00, 3'd0, 1, 0);
    apply("R2 wrap base3", 8'h05, 8'h00, 8'h00, 3'd3, 1, 0);
    apply("R2 base5 next", 8'h41, 8'h00, 8'h00, 3'd5, 1, 6);
  endtask

  task automatic t_r3_r9;
    apply("R3 R9 empty", 8'h00, 8'h00, 8'h00, 3'd2, 0, 0);
    apply("R3 R9 all masked", 8'hFF, 8'hFF, 8'h00, 3'd4, 0, 0);
  endtask

  task automatic t_r4;
    apply("R4 equal rank", 8'h08, 8'h00, 8'h08, 3'd0, 0, 0);
    apply("R4 higher rank", 8'h04, 8'h00, 8'h08, 3'd0, 1, 2);
    apply("R4 lower rank", 8'h10, 8'h00, 8'h08, 3'd0, 0, 0);
    apply("R4 rotated", 8'h01, 8'h00, 8'h40, 3'd6, 0, 0);
  endtask

  task automatic t_r5_r6;
    sm = 1;
    apply("R5 override on", 8'h10, 8'h02, 8'h02, 3'd0, 1, 4);
    sm = 0;
    apply("R6 override off", 8'h10, 8'h02, 8'h02, 3'd0, 0, 0);
  endtask

  task automatic t_r7;
    nest = 1; mas = 1;
    apply("R7 cascade ignored", 8'h08, 8'h00, 8'h04, 3'd0, 1, 3);
    apply("R7 cascade repick", 8'h04, 8'h00, 8'h04, 3'd0, 1, 2);
    mas = 0;
    apply("R7 secondary", 8'h08, 8'h00, 8'h04, 3'd0, 0, 0);
    nest = 0; mas = 1;
    apply("R7 nesting off", 8'h08, 8'h00, 8'h04, 3'd0, 0, 0);
    mas = 0;
  endtask

  task automatic t_sweep;
    logic [7:0] pats [4] = '{8'h90, 8'h3C, 8'h81, 8'h42};
    for (int b = 0; b < 8; b++) begin
      for (int p = 0; p < 4; p++) begin
        bit mv; int ml;
        @(negedge clk);
        req = pats[p]; msk = 8'h00; isr = 8'h00; base = 3'(b);
        #1;
        model(mv, ml);
        check("R2 R9 sweep line", int'(pick_line), ml);
        check("R2 sweep valid", int'(pick_valid), int'(mv));
      end
    end
  endtask

  initial begin
    t_reset();
    t_r1();
    t_r2();
    t_r3_r9();
    t_r4();
    t_r5_r6();
    t_r7();
    t_sweep();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule